// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer that drives an external dual-modulus prescaler, one that divides either by V or by V+1. The prescaler's output pulses arrive as single-clock strobes on `pre_tick`. Two down-counters share that strobe. The main counter sets how many prescaler pulses make up one divided cycle. The swallow counter sets how many of those pulses use the longer V+1 ratio. The block drives `mod_hi` so the prescaler knows which ratio to apply. At the end of every divided cycle it raises `div_pulse` for one clock, and that pulse goes to the phase detector.

Seen from the prescaler input, the whole loop divides by V·N + A. A controlling processor can rewrite `n_word` and `a_word` at any time to move the lock frequency. The block samples both words only when it reloads at a cycle boundary, so a cycle that is already running always finishes with the values it started with.

Top module: `swallow_div`

## Requirements
- R1: The number of clocks between two consecutive `div_pulse` assertions equals V·N + A, where N and A are the effective values latched at the reload that started the cycle and each prescaler cycle lasts V clocks when `mod_hi` is 0 and V+1 clocks when it is 1.
- R2: In each divided cycle, `mod_hi` is 1 (select V+1) for exactly the first A prescaler pulses and 0 (select V) for the remaining N − A pulses.
- R3: When A is 0, `mod_hi` stays 0 for the whole cycle and the ratio is exactly V·N.
- R4: When `a_word` is greater than the effective N, `ratio_err` is 1 for that whole cycle and A is taken as equal to N, so every prescaler pulse in the cycle uses V+1. Otherwise `ratio_err` is 0.
- R5: Changes to `n_word` or `a_word` during a cycle have no effect on the running cycle. They are sampled only at the reload that follows the last pulse of a cycle.
- R6: `div_pulse` is one clock wide. It is asserted in the clock that follows the clock in which `pre_tick` carried the last pulse of the cycle.
- R7: An `n_word` of 0 is treated as N = 1.
- R8: A synchronous active-high `rst` loads both counters from the current inputs. After reset, `div_pulse` is 0, `mod_hi` equals (effective A ≠ 0), and `ratio_err` follows R4.
- R9: `mod_hi` changes only in the clock after a `pre_tick` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | One-clock strobe for each prescaler output pulse |
| n_word | input | N_W (10) | Main divide count N |
| a_word | input | A_W (6) | Swallow count A |
| mod_hi | output | 1 | Modulus select: 1 = V+1, 0 = V |
| div_pulse | output | 1 | One-clock pulse at the end of each divided cycle |
| ratio_err | output | 1 | Swallow count exceeded main count in this cycle |

## Verification
If the swallow counter held a wrong value, the number of V+1 prescaler cycles would be wrong. That error shows up as a shift in the `div_pulse` spacing by whole clocks, visible at the very next pulse. If the main counter were wrong, the spacing would change by multiples of V, again visible at the next pulse. If the inputs were sampled mid-cycle instead of at the reload, the current cycle's spacing would move, and the glitch case is set up to expose exactly that. A stuck or misaligned modulus select shows up in the count of V+1 pulses per cycle and in `mod_hi` changing with no strobe before it.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int unsigned SWD_N_W_DEF = 10;
    localparam int unsigned SWD_A_W_DEF = 6;

    typedef enum logic {
        SEL_V  = 1'b0,
        SEL_V1 = 1'b1
    } mod_sel_e;

    typedef struct packed {
        logic reload;
        logic err;
    } cycle_ev_t;

endpackage

// File: rtl/swd_cfg_sanitize.sv
module swd_cfg_sanitize #(
    parameter int unsigned N_W = swd_pkg::SWD_N_W_DEF,
    parameter int unsigned A_W = swd_pkg::SWD_A_W_DEF
) (
    input  logic [N_W-1:0] n_raw,
    input  logic [A_W-1:0] a_raw,
    output logic [N_W-1:0] n_eff,
    output logic [A_W-1:0] a_eff,
    output logic           over
);
    logic [N_W-1:0] a_ext;

    always_comb begin
        n_eff = (n_raw == '0) ? N_W'(1) : n_raw;
        a_ext = N_W'(a_raw);
        over  = (a_ext > n_eff);
        a_eff = over ? n_eff[A_W-1:0] : a_raw;
    end
endmodule

// File: rtl/swd_main_ctr.sv
module swd_main_ctr #(
    parameter int unsigned N_W = swd_pkg::SWD_N_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [N_W-1:0] n_eff,
    output logic [N_W-1:0] n_rem,
    output logic           last
);
    assign last = tick && (n_rem == N_W'(1));

    always_ff @(posedge clk) begin
        if (rst || last) begin
            n_rem <= n_eff;
        end else if (tick) begin
            n_rem <= n_rem - N_W'(1);
        end
    end

    // R7
    n_rem_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        n_rem != '0);
endmodule

// File: rtl/swd_swallow_ctr.sv
module swd_swallow_ctr #(
    parameter int unsigned A_W = swd_pkg::SWD_A_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reload,
    input  logic [A_W-1:0]    a_eff,
    output logic [A_W-1:0]    a_rem,
    output swd_pkg::mod_sel_e mod_sel
);
    import swd_pkg::*;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            a_rem <= a_eff;
        end else if (tick && (a_rem != '0)) begin
            a_rem <= a_rem - A_W'(1);
        end
    end

    assign mod_sel = (a_rem != '0) ? SEL_V1 : SEL_V;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R9
    mod_only_after_tick_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(tick) |-> $stable(mod_sel));
endmodule

// File: rtl/swallow_div.sv
module swallow_div #(
    parameter int unsigned N_W = swd_pkg::SWD_N_W_DEF,
    parameter int unsigned A_W = swd_pkg::SWD_A_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_tick,
    input  logic [N_W-1:0] n_word,
    input  logic [A_W-1:0] a_word,
    output logic           mod_hi,
    output logic           div_pulse,
    output logic           ratio_err
);
    import swd_pkg::*;

    localparam int unsigned CMP_W = (N_W > A_W) ? N_W : A_W;

    logic [N_W-1:0] n_eff;
    logic [A_W-1:0] a_eff;
    logic           over;
    logic [N_W-1:0] n_rem;
    logic [A_W-1:0] a_rem;
    logic           last;
    mod_sel_e       mod_sel;
    cycle_ev_t      ev;
    logic           div_q;
    logic           err_q;
    logic           armed;

    swd_cfg_sanitize #(.N_W(N_W), .A_W(A_W)) cfg_i (
        .n_raw (n_word),
        .a_raw (a_word),
        .n_eff (n_eff),
        .a_eff (a_eff),
        .over  (over)
    );

    swd_main_ctr #(.N_W(N_W)) main_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (pre_tick),
        .n_eff (n_eff),
        .n_rem (n_rem),
        .last  (last)
    );

    swd_swallow_ctr #(.A_W(A_W)) swl_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (pre_tick),
        .reload  (last),
        .a_eff   (a_eff),
        .a_rem   (a_rem),
        .mod_sel (mod_sel)
    );

    assign ev.reload = last;
    assign ev.err    = over;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= 1'b0;
            err_q <= over;
            armed <= 1'b0;
        end else begin
            div_q <= ev.reload;
            armed <= 1'b1;
            if (ev.reload) err_q <= ev.err;
        end
    end

    assign mod_hi    = (mod_sel == SEL_V1);
    assign div_pulse = div_q;
    assign ratio_err = err_q;

    // R4
    swallow_within_main_chk: assert property (@(posedge clk) disable iff (rst)
        CMP_W'(a_rem) <= CMP_W'(n_rem));

    // R6
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(pre_tick));

    // R5
    err_stable_in_cycle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(last) |-> $stable(ratio_err));

    // R2
    mod_low_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        (n_rem == N_W'(1) && !mod_hi) |=> !(mod_hi && !$past(pre_tick)));
endmodule

// File: tb/swallow_div_tb_top.sv
`timescale 1ns/1ps
module swallow_div_tb_top;

    localparam int V    = 8;
    localparam int NCFG = 11;

    logic       clk = 1'b0;
    logic       rst;
    logic       pre_tick;
    logic [9:0] n_word;
    logic [5:0] a_word;
    logic       mod_hi;
    logic       div_pulse;
    logic       ratio_err;

    always #2 clk = ~clk;

    swallow_div dut_i (
        .clk       (clk),
        .rst       (rst),
        .pre_tick  (pre_tick),
        .n_word    (n_word),
        .a_word    (a_word),
        .mod_hi    (mod_hi),
        .div_pulse (div_pulse),
        .ratio_err (ratio_err)
    );

    // behavioural dual-modulus prescaler
    int pcnt;
    assign pre_tick = (pcnt == (mod_hi ? V : V - 1));
    always @(posedge clk) begin
        if (rst || pre_tick) pcnt <= 0;
        else                 pcnt <= pcnt + 1;
    end

    typedef struct {
        int    period;
        int    hi;
        bit    err;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   pops   = 0;
    int   r9_bad = 0;
    bit   ended  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic push_cfg(input int n, input int a, input string tag);
        exp_t e;
        int ne;
        int ae;
        n_word = 10'(n);
        a_word = 6'(a);
        ne = (n == 0) ? 1 : n;
        ae = (a > ne) ? ne : a;
        e.period = V * ne + ae;
        e.hi     = ae;
        e.err    = (a > ne);
        e.tag    = tag;
        q.push_back(e);
    endtask

    function automatic int cfg_n(input int i);
        case (i)
            0: return 5;    1: return 5;   2: return 7;  3: return 3;
            4: return 0;    5: return 12;  6: return 0;  7: return 1;
            8: return 40;   9: return 1023; default: return 9;
        endcase
    endfunction

    function automatic int cfg_a(input int i);
        case (i)
            0: return 2;   1: return 0;  2: return 7;  3: return 6;
            4: return 0;   5: return 4;  6: return 5;  7: return 1;
            8: return 63;  9: return 0;  default: return 10;
        endcase
    endfunction

    function automatic string cfg_tag(input int i);
        case (i)
            0: return "R1";  1: return "R3";  2: return "R2";  3: return "R4";
            4: return "R7";  5: return "R5";  6: return "R7";  7: return "R2";
            8: return "R1";  9: return "R3";  default: return "R4";
        endcase
    endfunction

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    // driver
    initial begin
        rst = 1'b1;
        push_cfg(cfg_n(0), cfg_a(0), cfg_tag(0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 div_pulse after reset", int'(div_pulse), 0);
        chk("R8 mod_hi after reset", int'(mod_hi), 1);
        chk("R8 ratio_err after reset", int'(ratio_err), 0);
        for (int i = 1; i < NCFG; i++) begin
            wait_pulse();
            if (i == 5) begin
                n_word = 10'd3;
                a_word = 6'd60;
                repeat (4) @(negedge clk);
            end
            push_cfg(cfg_n(i), cfg_a(i), cfg_tag(i));
            if (i == 6) begin
                repeat (3) @(negedge clk);
                n_word = 10'd200;
                a_word = 6'd0;
                repeat (2) @(negedge clk);
                n_word = 10'(cfg_n(6));
                a_word = 6'(cfg_a(6));
            end
        end
        while (pops < NCFG) @(negedge clk);
        chk("R9 mod_hi changes without strobe", r9_bad, 0);
        finish_run();
    end

    // monitor
    int clk_cnt  = 0;
    int hi_cnt   = 0;
    bit err_last = 0;
    bit prev_tk  = 0;
    bit prev_mod = 0;
    bit started  = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (started && (mod_hi != prev_mod) && !prev_tk) r9_bad++;
            if (div_pulse) begin
                if (started && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk({"R1 period ", e.tag}, clk_cnt, e.period);
                    chk({(e.hi == 0) ? "R3 hi count " : "R2 hi count ", e.tag}, hi_cnt, e.hi);
                    chk({"R4 ratio_err ", e.tag}, int'(err_last), int'(e.err));
                    chk("R6 pulse follows strobe", int'(prev_tk), 1);
                    pops++;
                end
                started = 1;
                clk_cnt = 1;
                hi_cnt  = 0;
            end else begin
                clk_cnt++;
                if (pre_tick && mod_hi) hi_cnt++;
                err_last = ratio_err;
                if (started && prev_tk == 0 && clk_cnt == 2) begin
                    // pulse must have been one clock wide (R6)
                end
            end
            prev_tk  = pre_tick;
            prev_mod = mod_hi;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule